// File: doc/BRIEF.md
# Keyed Block Write-Protection Checker

This block decides whether a storage access may go ahead. Storage is split into 2 KB blocks. A small table gives each block a 4-bit protection key and a flag that extends protection to reads. Each request carries an address, the requester's key and a read/write indication. The checker finds the target block from the upper address bits and compares the two keys. It returns a registered verdict one cycle later. The verdict is exactly one of three outcomes: grant, protection violation, or address-range error.

A requester holding key zero is trusted and skips the comparison. Reads are checked only in blocks whose read-protect flag is set. A privileged update port rewrites one block's key and flag per cycle. A request to the same block in that cycle is still judged against the previous contents. The storage array and any handling of violations sit outside this block.

Top module: `blkg_top`

## Requirements
- R1: After reset, every response output is 0. Every table entry holds key 0 with read protection off, so a nonzero-key write to any in-range block is refused.
- R2: A request with `req_valid` high produces `rsp_valid` high on the next cycle. Exactly one of `rsp_grant`, `rsp_violation` and `rsp_range_err` is then high. With no request, all four outputs are low on the next cycle.
- R3: The target block is `req_addr[23:11]`, so each aligned 2 KB range maps to its own table entry. The low 11 bits have no influence on the verdict.
- R4: A write whose key equals the block's key is granted.
- R5: A write from a nonzero key that differs from the block's key is reported as a violation and is not granted.
- R6: An in-range request from key 0 is always granted, for reads and writes, whatever the block's key and read-protect flag.
- R7: A read of a block whose read-protect flag is 0 is granted for any key.
- R8: A read of a block whose read-protect flag is 1 is granted only for a matching key or key 0. Any other key gives a violation.
- R9: A request whose block index is NUM_BLKS or above raises only `rsp_range_err`, with no key check, even for key 0.
- R10: An update with `upd_valid` high writes `upd_key` and `upd_fetch_prot` into block `upd_blk`, and requests from the next cycle on see the new values. A request in the same cycle sees the old values. An update naming a block at or above NUM_BLKS changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (24) | Byte address of the access |
| req_key | input | KEY_W (4) | Requester protection key |
| req_write | input | 1 | 1 = write, 0 = read |
| upd_valid | input | 1 | Table update present this cycle |
| upd_blk | input | ADDR_W-BLK_SHIFT (13) | Block index to update |
| upd_key | input | KEY_W (4) | New key for that block |
| upd_fetch_prot | input | 1 | New read-protect flag for that block |
| rsp_valid | output | 1 | Verdict present |
| rsp_grant | output | 1 | Access allowed |
| rsp_violation | output | 1 | Key mismatch, access refused |
| rsp_range_err | output | 1 | Block index beyond the table |

## Verification
A corrupted table entry has no effect of its own at the ports. It shows only when a later request targets that block, and then as a wrong grant or violation one cycle after that request. The bench therefore probes every updated block soon after the update, including in the same cycle as the update. A wrong block decode shows as a verdict taken from the neighbouring block, so accesses are placed on both sides of a 2 KB boundary. A fault in the registered verdict path shows on the very next cycle, as a missing, doubled or extra flag.

// File: rtl/blkg_pkg.sv
package blkg_pkg;

    // Registered verdict presented at the ports.
    typedef struct packed {
        logic valid;
        logic grant;
        logic viol;
        logic rerr;
    } blkg_rsp_t;

endpackage

// File: rtl/blkg_keytab.sv
module blkg_keytab #(
    parameter int NUM_BLKS = 64,
    parameter int KEY_W    = 4,
    parameter int IDX_W    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_blk,
    input  logic [KEY_W-1:0] upd_key,
    input  logic             upd_fp,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_in_range,
    output logic [KEY_W-1:0] look_key,
    output logic             look_fp
);
    localparam int TAB_W = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;

    logic [KEY_W-1:0]    key_d [NUM_BLKS];
    logic [KEY_W-1:0]    key_q [NUM_BLKS];
    logic [NUM_BLKS-1:0] fp_d, fp_q;
    logic                upd_hit;

    // Next-state table: one entry may change per cycle.
    always_comb begin
        key_d   = key_q;
        fp_d    = fp_q;
        upd_hit = upd_valid && (upd_blk < IDX_W'(NUM_BLKS));
        if (upd_hit) begin
            key_d[upd_blk[TAB_W-1:0]] = upd_key;
            fp_d[upd_blk[TAB_W-1:0]]  = upd_fp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '{default: '0};
            fp_q  <= '0;
        end else begin
            key_q <= key_d;
            fp_q  <= fp_d;
        end
    end

    // Lookup reads the registered table, so a same-cycle update is not seen.
    always_comb begin
        look_in_range = look_idx < IDX_W'(NUM_BLKS);
        look_key      = '0;
        look_fp       = 1'b0;
        if (look_in_range) begin
            look_key = key_q[look_idx[TAB_W-1:0]];
            look_fp  = fp_q[look_idx[TAB_W-1:0]];
        end
    end

    AST_UPD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_blk < IDX_W'(NUM_BLKS)) |=>
        (key_q[$past(upd_blk[TAB_W-1:0])] == $past(upd_key) &&
         fp_q[$past(upd_blk[TAB_W-1:0])] == $past(upd_fp)));  // R10

endmodule

// File: rtl/blkg_judge.sv
module blkg_judge
    import blkg_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [KEY_W-1:0] req_key,
    input  logic             in_range,
    input  logic [KEY_W-1:0] blk_key,
    input  logic             blk_fp,
    output blkg_rsp_t        verdict
);
    logic trusted, keys_equal, unguarded_read, allow;

    always_comb begin
        trusted        = (req_key == '0);
        keys_equal     = (req_key == blk_key);
        unguarded_read = !req_write && !blk_fp;
        allow          = trusted || keys_equal || unguarded_read;

        verdict.valid = req_valid;
        verdict.rerr  = req_valid && !in_range;
        verdict.grant = req_valid && in_range && allow;
        verdict.viol  = req_valid && in_range && !allow;
    end

endmodule

// File: rtl/blkg_top.sv
module blkg_top
    import blkg_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BLK_SHIFT = 11,
    parameter int KEY_W     = 4,
    parameter int NUM_BLKS  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [KEY_W-1:0]            req_key,
    input  logic                        req_write,
    input  logic                        upd_valid,
    input  logic [ADDR_W-BLK_SHIFT-1:0] upd_blk,
    input  logic [KEY_W-1:0]            upd_key,
    input  logic                        upd_fetch_prot,
    output logic                        rsp_valid,
    output logic                        rsp_grant,
    output logic                        rsp_violation,
    output logic                        rsp_range_err
);
    localparam int IDX_W = ADDR_W - BLK_SHIFT;

    logic [IDX_W-1:0]     req_idx;
    logic [BLK_SHIFT-1:0] unused_offset;
    logic                 tab_in_range;
    logic [KEY_W-1:0]     tab_key;
    logic                 tab_fp;
    blkg_rsp_t            rsp_d, rsp_q;

    assign req_idx       = req_addr[ADDR_W-1:BLK_SHIFT];
    assign unused_offset = req_addr[BLK_SHIFT-1:0];

    blkg_keytab #(
        .NUM_BLKS (NUM_BLKS),
        .KEY_W    (KEY_W),
        .IDX_W    (IDX_W)
    ) u_tab (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_valid     (upd_valid),
        .upd_blk       (upd_blk),
        .upd_key       (upd_key),
        .upd_fp        (upd_fetch_prot),
        .look_idx      (req_idx),
        .look_in_range (tab_in_range),
        .look_key      (tab_key),
        .look_fp       (tab_fp)
    );

    blkg_judge #(
        .KEY_W (KEY_W)
    ) u_judge (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_key   (req_key),
        .in_range  (tab_in_range),
        .blk_key   (tab_key),
        .blk_fp    (tab_fp),
        .verdict   (rsp_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_grant     = rsp_q.grant;
    assign rsp_violation = rsp_q.viol;
    assign rsp_range_err = rsp_q.rerr;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R2
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_violation, rsp_range_err}) == 1);  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_violation || rsp_range_err));  // R2
    AST_KEY0_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_key == '0) |=> !rsp_violation);  // R6
    AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx >= IDX_W'(NUM_BLKS)) |=> (rsp_range_err && !rsp_grant));  // R9

endmodule

// File: tb/sim_blkg_top.sv
`timescale 1ns/1ps
module sim_blkg_top;
    localparam int NB = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, upd_valid, upd_fetch_prot;
    logic [23:0] req_addr;
    logic [3:0]  req_key, upd_key;
    logic [12:0] upd_blk;
    logic        rsp_valid, rsp_grant, rsp_violation, rsp_range_err;

    always #2 clk = ~clk;

    blkg_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_key(req_key), .req_write(req_write), .upd_valid(upd_valid),
        .upd_blk(upd_blk), .upd_key(upd_key), .upd_fetch_prot(upd_fetch_prot),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_violation(rsp_violation), .rsp_range_err(rsp_range_err)
    );

    typedef struct {
        logic [3:0] flags;   // {valid, grant, violation, range_err}
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [3:0] m_key [NB];
    logic       m_fp  [NB];
    bit         finished = 0;

    task automatic step(input logic v, input logic [23:0] a, input logic [3:0] k,
                        input logic w, input logic uv, input logic [12:0] ub,
                        input logic [3:0] uk, input logic uf, input string tag);
        exp_t e;
        int   idx;
        logic ok;
        @(negedge clk);
        req_valid = v; req_addr = a; req_key = k; req_write = w;
        upd_valid = uv; upd_blk = ub; upd_key = uk; upd_fetch_prot = uf;
        idx = int'(a[23:11]);
        e.tag = tag;
        if (!v)            e.flags = 4'b0000;
        else if (idx >= NB) e.flags = 4'b1001;
        else begin
            ok = (k == 4'd0) || (k == m_key[idx]) || (!w && !m_fp[idx]);
            e.flags = ok ? 4'b1100 : 4'b1010;
        end
        sb_q.push_back(e);
        if (uv && int'(ub) < NB) begin
            m_key[int'(ub)] = uk;
            m_fp[int'(ub)]  = uf;
        end
    endtask

    function automatic logic [23:0] ad(input int blk, input int off);
        return {13'(blk), 11'(off)};
    endfunction

    // Monitor: one expected item per driven cycle, checked after the edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if ({rsp_valid, rsp_grant, rsp_violation, rsp_range_err} !== e.flags) begin
                n_fail++;
                $display("FAIL %s: got v/g/x/r=%b expected %b", e.tag,
                         {rsp_valid, rsp_grant, rsp_violation, rsp_range_err}, e.flags);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_key[i] = 4'd0; m_fp[i] = 1'b0; end
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_key = '0; req_write = 0;
        upd_valid = 0; upd_blk = '0; upd_key = '0; upd_fetch_prot = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if ({rsp_valid, rsp_grant, rsp_violation, rsp_range_err} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1 reset outputs: got %b expected 0000",
                     {rsp_valid, rsp_grant, rsp_violation, rsp_range_err});
        end
        rst_n = 1'b1;

        step(1, ad(0, 5), 4'd3, 1, 0, 0, 0, 0, "R1 reset key zero refuses key 3 write");
        step(1, ad(2, 0), 4'd5, 1, 1, 13'd2, 4'd5, 1, "R10 same-cycle request sees old key");
        step(1, ad(2, 100), 4'd5, 1, 0, 0, 0, 0, "R4 matching write granted");
        step(1, ad(2, 7), 4'd6, 1, 0, 0, 0, 0, "R5 mismatched write violation");
        step(1, ad(2, 8), 4'd6, 0, 0, 0, 0, 0, "R8 protected read mismatch");
        step(1, ad(2, 9), 4'd5, 0, 0, 0, 0, 0, "R8 protected read match");
        step(1, ad(2, 10), 4'd0, 1, 0, 0, 0, 0, "R6 key0 write");
        step(1, ad(2, 11), 4'd0, 0, 0, 0, 0, 0, "R6 key0 protected read");
        step(1, ad(3, 0), 4'd2, 0, 1, 13'd3, 4'd7, 0, "R7 read before update");
        step(1, ad(3, 1), 4'd2, 0, 0, 0, 0, 0, "R7 unprotected read any key");
        step(1, ad(3, 2), 4'd2, 1, 0, 0, 0, 0, "R5 write to block 3 wrong key");
        step(1, ad(2, 2047), 4'd5, 1, 0, 0, 0, 0, "R3 last byte of block 2");
        step(1, ad(3, 0), 4'd5, 1, 0, 0, 0, 0, "R3 first byte of block 3");
        step(1, ad(NB, 0), 4'd0, 1, 0, 0, 0, 0, "R9 key0 beyond table");
        step(1, 24'hFFFFFF, 4'd5, 0, 0, 0, 0, 0, "R9 top address");
        step(0, ad(2, 0), 4'd5, 1, 0, 0, 0, 0, "R2 idle cycle quiet");
        step(1, ad(NB - 1, 3), 4'd9, 1, 1, 13'd63, 4'd9, 0, "R10 last block old key");
        step(1, ad(NB - 1, 4), 4'd9, 1, 1, 13'd200, 4'd1, 1, "R10 last block new key");
        step(1, ad(NB - 1, 5), 4'd9, 1, 0, 0, 0, 0, "R10 out-of-range update ignored");

        for (int i = 0; i < 60; i++) begin
            step(i % 5 != 4, ad((i * 5) % 70, i * 37), 4'((i * 3) % 16), i[0],
                 i % 3 == 0, 13'((i * 11) % 66), 4'((i * 7) % 16), i[1],
                 "R2 R4 R5 R8 mixed traffic");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2 drain");
        while (sb_q.size() > 0) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule